// File: doc/BRIEF.md
# Dual-Issue Pairing Gate and Fetch Advance

This block decides, once per cycle, how much of a two-instruction fetch group a 2-wide in-order core issues. The fetch unit presents two consecutive 32-bit instructions, slot 0 at the current fetch address and slot 1 four bytes later. Each slot comes with a decoded descriptor: a valid flag, a control-transfer flag, a memory-access flag, a barrier (fence) flag, a register-write flag, a destination index and two source indices.

The gate holds the fetch address. When it can pair the group it steps that address by 8. When it cannot, it issues slot 0 alone, turns slot 1 into a bubble and steps by 4, so the dropped instruction comes back as slot 0 of the next group. A stall from downstream freezes the address. A taken redirect from the execute side loads a new target and beats every other cause.

All decisions are registered. The inputs sampled at a rising edge, which describe the group at the address `pc` shows before that edge, set `pc`, `issue0`, `pair` and `squash1` from that edge onward.

Top module: `dual_issue_gate`

## Requirements
- R1: While `rst` is high, and after the edge it is sampled on, `pc` is 0 and `issue0`, `pair` and `squash1` are 0.
- R2: When both slots are valid, no redirect or stall is present and no refusal rule applies, the next edge sets `pair`=1, `issue0`=1, `squash1`=0 and advances `pc` by 8.
- R3: If either slot has its control-transfer flag set (branch, direct jump or register jump), pairing is refused.
- R4: Pairing is refused when slot 0 writes a register whose index is nonzero and equal to slot 1's first source or to its second source.
- R5: A destination match as in R4 does not refuse pairing when slot 0's write flag is 0 or its destination index is 0.
- R6: Pairing is refused when both slots are memory accesses. A group with exactly one memory access may still pair.
- R7: Pairing is refused when either slot carries the fence flag.
- R8: A group that is not stalled, not redirected and not paired advances `pc` by 4, sets `issue0` to slot 0's valid flag, sets `pair`=0, and sets `squash1` to slot 1's valid flag.
- R9: With `stall`=1 and no redirect, `pc` keeps its value and `issue0`, `pair` and `squash1` become 0.
- R10: With `redir_vld`=1, `pc` loads `redir_pc` and `issue0`, `pair` and `squash1` become 0, whatever `stall` and the slot descriptors are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_vld | input | 1 | Slot 0 holds an instruction |
| s0_ctl | input | 1 | Slot 0 is a branch or jump |
| s0_mem | input | 1 | Slot 0 is a load or store |
| s0_fence | input | 1 | Slot 0 is a fence |
| s0_wen | input | 1 | Slot 0 writes a register |
| s0_rd | input | 5 | Slot 0 destination index |
| s0_rs1 | input | 5 | Slot 0 first source index |
| s0_rs2 | input | 5 | Slot 0 second source index |
| s1_vld | input | 1 | Slot 1 holds an instruction |
| s1_ctl | input | 1 | Slot 1 is a branch or jump |
| s1_mem | input | 1 | Slot 1 is a load or store |
| s1_fence | input | 1 | Slot 1 is a fence |
| s1_wen | input | 1 | Slot 1 writes a register |
| s1_rd | input | 5 | Slot 1 destination index |
| s1_rs1 | input | 5 | Slot 1 first source index |
| s1_rs2 | input | 5 | Slot 1 second source index |
| stall | input | 1 | Hold fetch and issue nothing |
| redir_vld | input | 1 | Taken redirect this cycle |
| redir_pc | input | 32 | Redirect target address |
| pc | output | 32 | Fetch address of the current group |
| issue0 | output | 1 | Slot 0 was issued |
| pair | output | 1 | Both slots were issued together |
| squash1 | output | 1 | Valid slot 1 was turned into a bubble |

## Verification
Redirect, stall and pairing can all be requested in the same cycle. The stimulus presents a fully pairable group while `stall` is high, then raises `redir_vld` together with `stall` and a pairable group. The outcome is judged on the next `pc`: it must hold in the first case and equal the target in the second, with no issue flags set in either. A second overlap, a register dependency inside a group that also holds a single memory access, shows that each refusal rule acts on its own.

// File: rtl/dualgate_pkg.sv
package dualgate_pkg;
  localparam int REG_AW = 5;

  typedef struct packed {
    logic              vld;
    logic              ctl;
    logic              mem;
    logic              fence;
    logic              wen;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
  } slot_desc_t;

  typedef enum logic [1:0] {
    ADV_PAIR = 2'd0,
    ADV_ONE  = 2'd1,
    ADV_HOLD = 2'd2,
    ADV_JUMP = 2'd3
  } adv_t;
endpackage

// File: rtl/dg_pair_check.sv
module dg_pair_check
  import dualgate_pkg::*;
#(
  parameter int SRC_CNT = 2
) (
  input  slot_desc_t lead,
  input  slot_desc_t trail,
  output logic       pair_ok
);
  logic [REG_AW-1:0] trail_src [SRC_CNT];
  logic [SRC_CNT-1:0] src_hit;
  logic               lead_writes;
  logic               any_ctl;
  logic               any_fence;
  logic               two_mem;

  assign trail_src[0] = trail.rs1;
  assign trail_src[1] = trail.rs2;
  assign lead_writes  = lead.wen && (lead.rd != '0);

  for (genvar g = 0; g < SRC_CNT; g++) begin : g_src
    assign src_hit[g] = lead_writes && (lead.rd == trail_src[g]);
  end

  assign any_ctl   = lead.ctl   | trail.ctl;
  assign any_fence = lead.fence | trail.fence;
  assign two_mem   = lead.mem   & trail.mem;

  assign pair_ok = lead.vld && trail.vld && !any_ctl && !any_fence &&
                   !two_mem && (src_hit == '0);

  always_comb begin
    if (pair_ok) begin
      a_pair_clean_r3: assert (!(lead.ctl || trail.ctl));
    end
  end
endmodule

// File: rtl/dg_pc_step.sv
module dg_pc_step
  import dualgate_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  adv_t            adv,
  input  logic [XLEN-1:0] pc_cur,
  input  logic [XLEN-1:0] jump_pc,
  output logic [XLEN-1:0] pc_nxt
);
  localparam logic [XLEN-1:0] STEP_ONE = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] STEP_TWO = XLEN'(2 * INSN_BYTES);

  always_comb begin
    unique case (adv)
      ADV_PAIR: pc_nxt = pc_cur + STEP_TWO;
      ADV_ONE:  pc_nxt = pc_cur + STEP_ONE;
      ADV_HOLD: pc_nxt = pc_cur;
      default:  pc_nxt = jump_pc;
    endcase
  end
endmodule

// File: rtl/dual_issue_gate.sv
module dual_issue_gate
  import dualgate_pkg::*;
#(
  parameter int               XLEN       = 32,
  parameter int               INSN_BYTES = 4,
  parameter logic [XLEN-1:0]  RESET_PC   = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s0_vld,
  input  logic                s0_ctl,
  input  logic                s0_mem,
  input  logic                s0_fence,
  input  logic                s0_wen,
  input  logic [REG_AW-1:0]   s0_rd,
  input  logic [REG_AW-1:0]   s0_rs1,
  input  logic [REG_AW-1:0]   s0_rs2,
  input  logic                s1_vld,
  input  logic                s1_ctl,
  input  logic                s1_mem,
  input  logic                s1_fence,
  input  logic                s1_wen,
  input  logic [REG_AW-1:0]   s1_rd,
  input  logic [REG_AW-1:0]   s1_rs1,
  input  logic [REG_AW-1:0]   s1_rs2,
  input  logic                stall,
  input  logic                redir_vld,
  input  logic [XLEN-1:0]     redir_pc,
  output logic [XLEN-1:0]     pc,
  output logic                issue0,
  output logic                pair,
  output logic                squash1
);
  localparam logic [XLEN-1:0] STEP_ONE = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] STEP_TWO = XLEN'(2 * INSN_BYTES);

  slot_desc_t      slot0, slot1;
  logic            pair_ok;
  adv_t            adv;
  logic [XLEN-1:0] pc_nxt;

  assign slot0 = '{vld: s0_vld, ctl: s0_ctl, mem: s0_mem, fence: s0_fence,
                   wen: s0_wen, rd: s0_rd, rs1: s0_rs1, rs2: s0_rs2};
  assign slot1 = '{vld: s1_vld, ctl: s1_ctl, mem: s1_mem, fence: s1_fence,
                   wen: s1_wen, rd: s1_rd, rs1: s1_rs1, rs2: s1_rs2};

  dg_pair_check #(.SRC_CNT(2)) u_check (
    .lead    (slot0),
    .trail   (slot1),
    .pair_ok (pair_ok)
  );

  always_comb begin
    if (redir_vld)    adv = ADV_JUMP;
    else if (stall)   adv = ADV_HOLD;
    else if (pair_ok) adv = ADV_PAIR;
    else              adv = ADV_ONE;
  end

  dg_pc_step #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_step (
    .adv     (adv),
    .pc_cur  (pc),
    .jump_pc (redir_pc),
    .pc_nxt  (pc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= RESET_PC;
      issue0  <= 1'b0;
      pair    <= 1'b0;
      squash1 <= 1'b0;
    end else begin
      pc      <= pc_nxt;
      issue0  <= (adv == ADV_PAIR) || ((adv == ADV_ONE) && s0_vld);
      pair    <= (adv == ADV_PAIR);
      squash1 <= (adv == ADV_ONE) && s1_vld;
    end
  end

  p_redirect_wins_r10: assert property (@(posedge clk) disable iff (rst)
    redir_vld |=> (pc == $past(redir_pc)) && !issue0 && !pair && !squash1);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (stall && !redir_vld) |=> $stable(pc) && !issue0 && !pair);

  p_pair_step_r2: assert property (@(posedge clk) disable iff (rst)
    (pair_ok && !stall && !redir_vld) |=> pair && (pc == $past(pc) + STEP_TWO));

  p_single_step_r8: assert property (@(posedge clk) disable iff (rst)
    (!pair_ok && !stall && !redir_vld) |=> !pair && (pc == $past(pc) + STEP_ONE));

  p_outcome_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(pair && squash1));

  p_pair_needs_lead_r2: assert property (@(posedge clk) disable iff (rst)
    pair |-> issue0);
endmodule

// File: tb/dual_issue_gate_test.sv
module dual_issue_gate_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        s0_vld, s0_ctl, s0_mem, s0_fence, s0_wen;
  logic [4:0]  s0_rd, s0_rs1, s0_rs2;
  logic        s1_vld, s1_ctl, s1_mem, s1_fence, s1_wen;
  logic [4:0]  s1_rd, s1_rs1, s1_rs2;
  logic        stall, redir_vld;
  logic [31:0] redir_pc;
  logic [31:0] pc;
  logic        issue0, pair, squash1;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_pc;

  always #4 clk = ~clk;

  dual_issue_gate uut (
    .clk(clk), .rst(rst),
    .s0_vld(s0_vld), .s0_ctl(s0_ctl), .s0_mem(s0_mem), .s0_fence(s0_fence),
    .s0_wen(s0_wen), .s0_rd(s0_rd), .s0_rs1(s0_rs1), .s0_rs2(s0_rs2),
    .s1_vld(s1_vld), .s1_ctl(s1_ctl), .s1_mem(s1_mem), .s1_fence(s1_fence),
    .s1_wen(s1_wen), .s1_rd(s1_rd), .s1_rs1(s1_rs1), .s1_rs2(s1_rs2),
    .stall(stall), .redir_vld(redir_vld), .redir_pc(redir_pc),
    .pc(pc), .issue0(issue0), .pair(pair), .squash1(squash1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic quiet();
    {s0_vld, s0_ctl, s0_mem, s0_fence, s0_wen} = '0;
    {s1_vld, s1_ctl, s1_mem, s1_fence, s1_wen} = '0;
    s0_rd = 5'd1; s0_rs1 = 5'd2; s0_rs2 = 5'd3;
    s1_rd = 5'd4; s1_rs1 = 5'd5; s1_rs2 = 5'd6;
    stall = 0; redir_vld = 0; redir_pc = '0;
  endtask

  // two valid ALU ops, slot 0 writes x1, slot 1 reads x5/x6
  task automatic clean_pair();
    quiet();
    s0_vld = 1; s0_wen = 1; s1_vld = 1; s1_wen = 1;
  endtask

  // apply current inputs for one edge, then check the registered outcome
  task automatic step(input string tag, input logic e_iss0, input logic e_pair,
                      input logic e_sq);
    @(posedge clk); #2;
    chk({tag, " pc"}, pc, exp_pc);
    chk({tag, " issue0"}, 32'(issue0), 32'(e_iss0));
    chk({tag, " pair"}, 32'(pair), 32'(e_pair));
    chk({tag, " squash1"}, 32'(squash1), 32'(e_sq));
    @(negedge clk);
  endtask

  task automatic t_reset();
    quiet(); clean_pair(); rst = 1;
    @(posedge clk); @(posedge clk); #2;
    exp_pc = 32'h0;
    chk("R1 pc", pc, 32'h0);
    chk("R1 issue0", 32'(issue0), 0);
    chk("R1 pair", 32'(pair), 0);
    chk("R1 squash1", 32'(squash1), 0);
    @(negedge clk); rst = 0; quiet();
  endtask

  task automatic t_pair();
    clean_pair(); exp_pc += 8; step("R2 clean", 1, 1, 0);
    clean_pair(); s0_mem = 1; exp_pc += 8; step("R6 one mem", 1, 1, 0);
    clean_pair(); s1_mem = 1; exp_pc += 8; step("R6 one mem slot1", 1, 1, 0);
  endtask

  task automatic t_ctl();
    clean_pair(); s0_ctl = 1; exp_pc += 4; step("R3 slot0 ctl", 1, 0, 1);
    clean_pair(); s1_ctl = 1; exp_pc += 4; step("R3 slot1 ctl", 1, 0, 1);
  endtask

  task automatic t_raw();
    clean_pair(); s0_rd = 5'd9; s1_rs1 = 5'd9; exp_pc += 4;
    step("R4 rs1 hit", 1, 0, 1);
    clean_pair(); s0_rd = 5'd9; s1_rs2 = 5'd9; exp_pc += 4;
    step("R4 rs2 hit", 1, 0, 1);
    clean_pair(); s0_rd = 5'd9; s1_rs1 = 5'd9; s0_mem = 1; exp_pc += 4;
    step("R4 hit with one mem", 1, 0, 1);
    clean_pair(); s0_rd = 5'd0; s1_rs1 = 5'd0; exp_pc += 8;
    step("R5 x0 dest", 1, 1, 0);
    clean_pair(); s0_wen = 0; s0_rd = 5'd9; s1_rs2 = 5'd9; exp_pc += 8;
    step("R5 no write", 1, 1, 0);
  endtask

  task automatic t_mem_fence();
    clean_pair(); s0_mem = 1; s1_mem = 1; exp_pc += 4; step("R6 two mem", 1, 0, 1);
    clean_pair(); s0_fence = 1; exp_pc += 4; step("R7 fence slot0", 1, 0, 1);
    clean_pair(); s1_fence = 1; exp_pc += 4; step("R7 fence slot1", 1, 0, 1);
  endtask

  task automatic t_single();
    clean_pair(); s1_vld = 0; exp_pc += 4; step("R8 slot1 empty", 1, 0, 0);
    clean_pair(); s0_vld = 0; exp_pc += 4; step("R8 slot0 empty", 0, 0, 1);
  endtask

  task automatic t_stall();
    clean_pair(); stall = 1; step("R9 stall pairable", 0, 0, 0);
    clean_pair(); stall = 1; s0_ctl = 1; step("R9 stall single", 0, 0, 0);
  endtask

  task automatic t_redirect();
    clean_pair(); stall = 1; redir_vld = 1; redir_pc = 32'h0000_4A40;
    exp_pc = 32'h0000_4A40; step("R10 over stall", 0, 0, 0);
    clean_pair(); s0_ctl = 1; redir_vld = 1; redir_pc = 32'hFFFF_FFF8;
    exp_pc = 32'hFFFF_FFF8; step("R10 over single", 0, 0, 0);
    clean_pair(); exp_pc += 8; step("R2 wrap after redirect", 1, 1, 0);
  endtask

  initial begin
    quiet(); rst = 1; exp_pc = '0;
    @(negedge clk);
    t_reset();
    t_pair();
    t_ctl();
    t_raw();
    t_mem_fence();
    t_single();
    t_stall();
    t_redirect();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule